// File: doc/BRIEF.md
# Stack Pointer Delta Engine for a Multi-Slot Decoder

This block sits next to a group of parallel instruction decoders and takes over the stack-pointer arithmetic of push, pop, call and return. These instructions would otherwise each issue an add or subtract micro-op. Instead they adjust a small signed offset held in the front end, and the architectural stack pointer is always the core stack pointer plus that offset. Every cycle up to four decoded descriptors arrive. The offset ripples through them in slot order, and each slot is handed the offset value in flight at that slot, so that its memory address can be patched. The register keeps the offset left after the last slot.

When an instruction reads the stack pointer directly, or when an update would push the offset outside its signed range, the block asks for a sync micro-op in front of that slot. The sync folds the current offset into the core stack pointer, and the offset then restarts from zero. No sync is requested while the offset is already zero. Each accepted instruction receives a tag in a circular recovery table. The table stores the offset seen by the instruction and the amount the instruction adds to it. A flush naming a tag restores the offset to its value either before or after that instruction.

Top module: `stk_delta_engine`

## Requirements
- R1: After reset the held offset is 0, no sync is requested, and the first accepted instruction receives tag 0.
- R2: Kind codes are 0 none, 1 push, 2 pop, 3 call, 4 return, 5 return-with-immediate. The size bit selects 4 bytes when 1 and 2 bytes when 0. Push and call add minus the size. Pop and return add plus the size. Return-with-immediate adds the size plus the unsigned immediate.
- R3: Each slot outputs the offset in flight at that slot: the held offset, updated by every earlier valid slot of the same cycle. An invalid slot passes the offset through unchanged. At the clock edge the held offset takes the value left after the last slot.
- R4: A valid slot with its stack-read flag set, arriving while the in-flight offset is nonzero, raises that slot's sync request with the in-flight offset as the sync amount. That slot's output offset is 0, and later slots start from 0.
- R5: No sync is requested by a slot whose in-flight offset is zero.
- R6: If applying a slot's amount would take the offset outside -2048..2047, a sync of the current offset is requested before that slot. The slot then sees offset 0 and applies its amount from 0. Reaching exactly -2048 or 2047 needs no sync.
- R7: Valid slots receive consecutive tags modulo 32 in slot order, starting from the write pointer. The pointer advances by the number of valid slots, wrapping at 32.
- R8: For each tagged instruction the table records the offset the slot output (taken after any sync for it) and the instruction's amount.
- R9: A flush with a tag and an after bit loads the held offset with the recorded offset (after bit 0) or the recorded offset plus the recorded amount (after bit 1). It sets the write pointer to the tag (after bit 0) or the tag plus one (after bit 1). The decode group presented in the flush cycle is ignored: it requests no sync, changes no offset and takes no tag.
- R10: A cycle with no valid slot and no flush leaves the held offset and the write pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | LANES | Slot holds a decoded instruction |
| dec_kind | input | 3*LANES | Stack-operation kind per slot (R2 codes) |
| dec_size4 | input | LANES | Operand size: 1 = 4 bytes, 0 = 2 bytes |
| dec_sp_read | input | LANES | Instruction reads the stack pointer explicitly |
| dec_imm | input | IMMW*LANES | Unsigned immediate for return-with-immediate |
| flush_valid | input | 1 | Restore request |
| flush_idx | input | AW | Tag of the instruction to restore around |
| flush_after | input | 1 | 1 = restore after that instruction, 0 = before it |
| slot_delta | output | DW*LANES | Signed offset in flight at each slot |
| slot_tag | output | AW*LANES | Recovery-table tag for each slot |
| sync_valid | output | LANES | Sync micro-op requested before the slot |
| sync_amount | output | DW*LANES | Signed offset folded in by that sync |

## Verification
Two events can land in the same cycle. In the first, a flush arrives together with a decode group that would itself request a sync: a stack-reading slot while the offset is nonzero. The bench presents both at once, expects no sync, and then confirms that the restored offset and the restored tag pointer show up in the following cycle with no trace of the ignored group. In the second, one group mixes stack-reading slots with updates. A sync and an offset update then occur in adjacent slots of a single cycle, and the sync amounts, the zero restarts and the recorded post-sync offsets are compared through a later flush.

// File: rtl/stkd_pkg.sv
package stkd_pkg;

  // stack-operation kind codes
  localparam logic [2:0] SK_NONE = 3'd0;
  localparam logic [2:0] SK_PUSH = 3'd1;
  localparam logic [2:0] SK_POP  = 3'd2;
  localparam logic [2:0] SK_CALL = 3'd3;
  localparam logic [2:0] SK_RET  = 3'd4;
  localparam logic [2:0] SK_RETN = 3'd5;

  // signed change an instruction makes to the offset
  function automatic int stk_effect(input logic [2:0] kind, input logic size4, input int imm);
    int unit;
    unit = size4 ? 4 : 2;
    case (kind)
      SK_PUSH, SK_CALL: return -unit;
      SK_POP,  SK_RET:  return unit;
      SK_RETN:          return unit + imm;
      default:          return 0;
    endcase
  endfunction

  // true when v is representable in a dw-bit two's complement field
  function automatic logic fits_signed(input int v, input int dw);
    return (v >= -(1 <<< (dw - 1))) && (v <= (1 <<< (dw - 1)) - 1);
  endfunction

endpackage

// File: rtl/stkd_slot.sv
module stkd_slot
  import stkd_pkg::*;
#(
  parameter int DW   = 12,
  parameter int IMMW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [2:0]           kind,
  input  logic                 size4,
  input  logic                 sp_read,
  input  logic [IMMW-1:0]      imm,
  input  logic signed [DW-1:0] d_in,
  output logic signed [DW-1:0] d_at,
  output logic signed [DW-1:0] d_out,
  output logic signed [DW-1:0] eff,
  output logic                 sync_req,
  output logic signed [DW-1:0] sync_amt
);

  int   eff_i;
  int   sum_i;
  logic range_hit;
  logic need_sync;

  always_comb begin
    eff_i     = stk_effect(kind, size4, int'(imm));
    sum_i     = int'(d_in) + eff_i;
    range_hit = !fits_signed(sum_i, DW);
    need_sync = valid && (d_in != '0) && (sp_read || range_hit);
    eff       = DW'(eff_i);
    d_at      = need_sync ? '0 : d_in;
    d_out     = valid ? (d_at + eff) : d_in;
    sync_req  = need_sync;
    sync_amt  = need_sync ? d_in : '0;
  end

  // R4
  sp_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sp_read) |-> (d_at == '0));

  // R5
  sync_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> (sync_amt != '0));

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (d_out == d_in && !sync_req));

endmodule

// File: rtl/stkd_tagger.sv
module stkd_tagger #(
  parameter int LANES = 4,
  parameter int AW    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES-1:0]   valid,
  input  logic               flush,
  input  logic [AW-1:0]      flush_idx,
  input  logic               flush_after,
  output logic [LANES*AW-1:0] tags
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] run;

  always_comb begin
    run = ptr_q;
    for (int l = 0; l < LANES; l++) begin
      tags[l*AW +: AW] = run;
      if (valid[l]) run = run + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (flush) ptr_q <= flush_idx + AW'(flush_after);
    else            ptr_q <= run;
  end

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && valid == '0) |=> $stable(ptr_q));

endmodule

// File: rtl/stkd_rtab.sv
module stkd_rtab #(
  parameter int LANES = 4,
  parameter int DEPTH = 32,
  parameter int DW    = 12,
  parameter int AW    = 5
) (
  input  logic                   clk,
  input  logic [LANES-1:0]       wr_en,
  input  logic [LANES*AW-1:0]    wr_idx,
  input  logic [LANES*DW-1:0]    wr_before,
  input  logic [LANES*DW-1:0]    wr_eff,
  input  logic [AW-1:0]          rd_idx,
  input  logic                   rd_after,
  output logic signed [DW-1:0]   rd_val
);

  logic signed [DW-1:0] before_q [DEPTH];
  logic signed [DW-1:0] eff_q    [DEPTH];

  // lanes carry distinct tags, so no two writes collide
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en[l]) begin
        before_q[wr_idx[l*AW +: AW]] <= wr_before[l*DW +: DW];
        eff_q[wr_idx[l*AW +: AW]]    <= wr_eff[l*DW +: DW];
      end
    end
  end

  always_comb begin
    rd_val = before_q[rd_idx] + (rd_after ? eff_q[rd_idx] : DW'(0));
  end

endmodule

// File: rtl/stk_delta_engine.sv
module stk_delta_engine #(
  parameter int LANES = 4,
  parameter int DW    = 12,
  parameter int IMMW  = 10,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        dec_valid,
  input  logic [LANES*3-1:0]      dec_kind,
  input  logic [LANES-1:0]        dec_size4,
  input  logic [LANES-1:0]        dec_sp_read,
  input  logic [LANES*IMMW-1:0]   dec_imm,
  input  logic                    flush_valid,
  input  logic [AW-1:0]           flush_idx,
  input  logic                    flush_after,
  output logic [LANES*DW-1:0]     slot_delta,
  output logic [LANES*AW-1:0]     slot_tag,
  output logic [LANES-1:0]        sync_valid,
  output logic [LANES*DW-1:0]     sync_amount
);

  // IMMW must stay below DW-1 so one instruction's amount fits the offset
  logic signed [DW-1:0] delta_q;
  logic signed [DW-1:0] chain [LANES+1];
  logic [LANES-1:0]     lane_v;
  logic [LANES*DW-1:0]  eff_flat;
  logic signed [DW-1:0] restore_val;

  assign lane_v   = dec_valid & ~{LANES{flush_valid}};
  assign chain[0] = delta_q;

  for (genvar g = 0; g < LANES; g++) begin : g_slot
    logic signed [DW-1:0] at_w, eff_w, amt_w;
    stkd_slot #(.DW(DW), .IMMW(IMMW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (lane_v[g]),
      .kind     (dec_kind[g*3 +: 3]),
      .size4    (dec_size4[g]),
      .sp_read  (dec_sp_read[g]),
      .imm      (dec_imm[g*IMMW +: IMMW]),
      .d_in     (chain[g]),
      .d_at     (at_w),
      .d_out    (chain[g+1]),
      .eff      (eff_w),
      .sync_req (sync_valid[g]),
      .sync_amt (amt_w)
    );
    assign slot_delta[g*DW +: DW]  = at_w;
    assign eff_flat[g*DW +: DW]    = eff_w;
    assign sync_amount[g*DW +: DW] = amt_w;
  end

  stkd_tagger #(.LANES(LANES), .AW(AW)) u_tag (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (lane_v),
    .flush       (flush_valid),
    .flush_idx   (flush_idx),
    .flush_after (flush_after),
    .tags        (slot_tag)
  );

  stkd_rtab #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rtab (
    .clk       (clk),
    .wr_en     (lane_v),
    .wr_idx    (slot_tag),
    .wr_before (slot_delta),
    .wr_eff    (eff_flat),
    .rd_idx    (flush_idx),
    .rd_after  (flush_after),
    .rd_val    (restore_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           delta_q <= '0;
    else if (flush_valid) delta_q <= restore_val;
    else                  delta_q <= chain[LANES];
  end

  // R10
  delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_valid && dec_valid == '0) |=> $stable(delta_q));

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (sync_valid == '0));

  // R9
  flush_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (slot_tag[AW-1:0] == AW'($past(flush_idx) + AW'($past(flush_after)))));

  // R4
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid[0] |-> (slot_delta[DW-1:0] == '0));

endmodule

// File: tb/test_stk_delta_engine.sv
`timescale 1ns/1ps
module test_stk_delta_engine;

  localparam int LANES = 4;
  localparam int DW    = 12;
  localparam int IMMW  = 10;
  localparam int AW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0]      dec_valid;
  logic [LANES*3-1:0]    dec_kind;
  logic [LANES-1:0]      dec_size4;
  logic [LANES-1:0]      dec_sp_read;
  logic [LANES*IMMW-1:0] dec_imm;
  logic                  flush_valid;
  logic [AW-1:0]         flush_idx;
  logic                  flush_after;
  logic [LANES*DW-1:0]   slot_delta;
  logic [LANES*AW-1:0]   slot_tag;
  logic [LANES-1:0]      sync_valid;
  logic [LANES*DW-1:0]   sync_amount;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  stk_delta_engine i_stk_delta_engine (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
    .dec_size4(dec_size4), .dec_sp_read(dec_sp_read), .dec_imm(dec_imm),
    .flush_valid(flush_valid), .flush_idx(flush_idx), .flush_after(flush_after),
    .slot_delta(slot_delta), .slot_tag(slot_tag), .sync_valid(sync_valid),
    .sync_amount(sync_amount)
  );

  function automatic int dlt(int l);
    return int'($signed(slot_delta[l*DW +: DW]));
  endfunction
  function automatic int amt(int l);
    return int'($signed(sync_amount[l*DW +: DW]));
  endfunction
  function automatic int tg(int l);
    return int'(slot_tag[l*AW +: AW]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    dec_valid = '0; dec_kind = '0; dec_size4 = '0; dec_sp_read = '0;
    dec_imm = '0; flush_valid = 1'b0; flush_idx = '0; flush_after = 1'b0;
  endtask

  task automatic lane(int l, logic [2:0] k, logic s4, logic spr, int imm);
    dec_valid[l] = 1'b1;
    dec_kind[l*3 +: 3] = k;
    dec_size4[l] = s4;
    dec_sp_read[l] = spr;
    dec_imm[l*IMMW +: IMMW] = IMMW'(imm);
  endtask

  // move to the next drive point: after the pending edge, inputs cleared
  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic flush_to(int idx, logic after);
    step();
    flush_valid = 1'b1; flush_idx = AW'(idx); flush_after = after;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "offset after reset", dlt(0), 0);
    chk("R1", "sync after reset", int'(sync_valid), 0);
    lane(0, 3'd1, 1'b1, 1'b0, 0);
    #1;
    chk("R1", "first tag", tg(0), 0);
  endtask

  task automatic t_accumulate();
    do_reset();
    lane(0, 3'd1, 1'b1, 1'b0, 0);  // push 4
    lane(1, 3'd1, 1'b0, 1'b0, 0);  // push 2
    lane(2, 3'd2, 1'b1, 1'b0, 0);  // pop 4
    lane(3, 3'd3, 1'b1, 1'b0, 0);  // call 4
    #1;
    chk("R2", "slot1 after push4", dlt(1), -4);
    chk("R2", "slot2 after push2", dlt(2), -6);
    chk("R3", "slot3 after pop4", dlt(3), -2);
    chk("R7", "tag slot3", tg(3), 3);
    step();
    lane(0, 3'd5, 1'b1, 1'b0, 20); // return imm 20
    lane(2, 3'd2, 1'b0, 1'b0, 0);  // pop 2
    lane(3, 3'd0, 1'b1, 1'b0, 0);  // none
    #1;
    chk("R3", "held offset after call", dlt(0), -6);
    chk("R3", "invalid slot passes", dlt(1), 18);
    chk("R2", "slot3 after pop2", dlt(3), 20);
    chk("R7", "tag skips invalid slot", tg(2), 5);
    chk("R7", "tag slot3 second group", tg(3), 6);
    step();
    #1;
    chk("R3", "final offset", dlt(0), 20);
    step();
    #1;
    chk("R10", "idle holds offset", dlt(0), 20);
    chk("R10", "idle holds pointer", tg(0), 7);
  endtask

  task automatic t_sync_read();
    do_reset();
    lane(0, 3'd1, 1'b1, 1'b0, 0);
    lane(1, 3'd0, 1'b1, 1'b1, 0);
    lane(2, 3'd1, 1'b1, 1'b0, 0);
    lane(3, 3'd0, 1'b1, 1'b1, 0);
    #1;
    chk("R4", "sync pattern", int'(sync_valid), 4'b1010);
    chk("R4", "sync amount slot1", amt(1), -4);
    chk("R4", "sync amount slot3", amt(3), -4);
    chk("R4", "slot1 restarts at zero", dlt(1), 0);
    chk("R4", "slot2 from zero", dlt(2), 0);
    step();
    #1;
    chk("R4", "held offset after syncs", dlt(0), 0);
    flush_to(3, 1'b0);
    step();
    #1;
    chk("R8", "recorded post-sync offset", dlt(0), 0);
    flush_to(2, 1'b1);
    step();
    #1;
    chk("R8", "recorded offset plus amount", dlt(0), -4);
  endtask

  task automatic t_no_sync_zero();
    do_reset();
    lane(0, 3'd0, 1'b1, 1'b1, 0);
    lane(1, 3'd1, 1'b1, 1'b0, 0);
    lane(2, 3'd2, 1'b1, 1'b0, 0);
    lane(3, 3'd0, 1'b1, 1'b1, 0);
    #1;
    chk("R5", "no sync at zero offset", int'(sync_valid), 0);
    chk("R5", "slot3 offset", dlt(3), 0);
  endtask

  task automatic t_range_pos();
    do_reset();
    for (int l = 0; l < LANES; l++) lane(l, 3'd5, 1'b1, 1'b0, 1000);
    #1;
    chk("R6", "overflow sync pattern", int'(sync_valid), 4'b0100);
    chk("R6", "overflow sync amount", amt(2), 2008);
    chk("R6", "slot2 restarts", dlt(2), 0);
    chk("R6", "slot3 offset", dlt(3), 1004);
    step();
    #1;
    chk("R6", "final after overflow", dlt(0), 2008);
  endtask

  task automatic t_range_neg();
    int syncs = 0;
    do_reset();
    for (int c = 0; c < 128; c++) begin
      for (int l = 0; l < LANES; l++) lane(l, 3'd1, 1'b1, 1'b0, 0);
      #1;
      if (sync_valid != '0) syncs++;
      step();
    end
    #1;
    chk("R6", "no sync down to -2048", syncs, 0);
    chk("R6", "offset at lower bound", dlt(0), -2048);
    lane(0, 3'd1, 1'b1, 1'b0, 0);
    #1;
    chk("R6", "underflow sync", int'(sync_valid), 1);
    chk("R6", "underflow sync amount", amt(0), -2048);
    chk("R7", "tag wrapped to 0", tg(0), 0);
    step();
    #1;
    chk("R6", "offset after underflow", dlt(0), -4);
  endtask

  task automatic t_flush();
    do_reset();
    lane(0, 3'd1, 1'b1, 1'b0, 0);  // 0 -> -4
    lane(1, 3'd1, 1'b1, 1'b0, 0);  // -4 -> -8
    lane(2, 3'd2, 1'b0, 1'b0, 0);  // -8 -> -6
    lane(3, 3'd5, 1'b1, 1'b0, 8);  // -6 -> 6
    step();
    #1;
    chk("R3", "offset before flush", dlt(0), 6);
    flush_valid = 1'b1; flush_idx = AW'(2); flush_after = 1'b0;
    lane(0, 3'd0, 1'b1, 1'b1, 0);  // would sync if accepted
    #1;
    chk("R9", "no sync during flush", int'(sync_valid), 0);
    step();
    #1;
    chk("R9", "restore before tag 2", dlt(0), -8);
    chk("R9", "pointer to tag 2", tg(0), 2);
    flush_to(3, 1'b1);
    step();
    #1;
    chk("R9", "restore after tag 3", dlt(0), 6);
    chk("R9", "pointer to tag 4", tg(0), 4);
    flush_to(1, 1'b1);
    step();
    #1;
    chk("R9", "restore after tag 1", dlt(0), -8);
    flush_to(0, 1'b0);
    step();
    #1;
    chk("R9", "restore before tag 0", dlt(0), 0);
    chk("R9", "pointer to tag 0", tg(0), 0);
  endtask

  initial begin
    clear_in();
    t_reset();
    t_accumulate();
    t_sync_read();
    t_no_sync_zero();
    t_range_pos();
    t_range_neg();
    t_flush();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule